// File: doc/BRIEF.md
# Half-Bridge Complementary PWM Generator with Dead-Band

This block produces two active-high PWM outputs for driving the two switches of a half-bridge. An up-counting timer runs from zero to a programmed period value. The primary output follows the duty portion of each period. The secondary output follows the remaining portion. A programmable dead-band count delays every inactive-to-active transition of either output. As a result, the high-side and low-side switches never conduct together.

Period, duty and dead-band settings are sampled only at period boundaries. The same applies to the first cycle after enable. Software or a controller may therefore change them at any time without producing a period with mixed settings. A one-cycle strobe marks the first timer slot of every period. Deasserting enable parks both outputs low and clears the timer. Reasserting it starts a fresh period.

Top module: `hb_pwm`

## Requirements
- R1: The timer counts 0, 1, ..., PR and then returns to 0, so every period lasts exactly PR+1 clock cycles and the timer never exceeds the working period value.
- R2: With a dead-band count of 0, the primary output is high exactly in timer slots below the duty value and the secondary output is high in all other slots of the period, so exactly one output is high in every running cycle.
- R3: When the nominal phase switches to an output, that output goes high only after the dead-band count of clock cycles has elapsed. With duty D, dead-band T and period PR in steady state, the primary output is high for D-T cycles and the secondary for PR+1-D-T cycles per period.
- R4: When the dead-band count is equal to or greater than an output's nominal active width, that output stays low for the whole period.
- R5: The primary and secondary outputs are never high in the same cycle.
- R6: A duty of 0 keeps the primary output low and, in steady state, the secondary output high for the whole period. A duty greater than PR keeps the secondary output low and, in steady state, the primary output high for the whole period.
- R7: Period, duty and dead-band inputs take effect only at the next period boundary; a change in mid-period leaves the rest of that period unaltered.
- R8: While reset is high or enable is low, both outputs and the strobe are low one clock later and the timer is cleared. After enable rises, the first running cycle is timer slot 0, and that slot counts as a nominal turn-on of the primary output.
- R9: The strobe is high for exactly the first timer slot of each period, including the first period after enable, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low forces both outputs low and clears the timer |
| period_i | input | CNT_W | Period value PR (period = PR+1 clocks), loaded at a boundary |
| duty_i | input | CNT_W | Duty value, loaded at a boundary |
| dead_i | input | DB_W | Dead-band count in clock cycles, loaded at a boundary |
| pwm_a_o | output | 1 | Primary PWM output, active high |
| pwm_b_o | output | 1 | Secondary (complementary) PWM output, active high |
| strobe_o | output | 1 | One-cycle marker of timer slot 0 of each period |

## Verification
The bound checker tests, on every cycle, that the two outputs never overlap and that the timer stays within the working period. It also checks that the strobe coincides with slot 0, that a zero dead-band gives strictly complementary outputs, that any rising output with a nonzero dead-band was preceded by a cycle with the other output low, and that disabling silences everything one cycle later. Pulse widths under each dead-band value, whole-period suppression when the delay exceeds an active window, and the extreme duty values can only be shown by the bench's scenarios. The same holds for the deferred effect of mid-period setting changes and the restart at slot 0 after enable. The bench checks these with a cycle-accurate reference model and with per-period pulse counts.

// File: rtl/hb_pwm_pkg.sv
package hb_pwm_pkg;

    // Default widths shared by the timer and the dead-band logic.
    localparam int HB_CNT_W = 8;
    localparam int HB_DB_W  = 7;

    // Number of output phases driven by the dead-band stage.
    localparam int HB_NUM_OUT = 2;

    // Index of each output inside the gated output vector.
    localparam int HB_OUT_PRI = 0;
    localparam int HB_OUT_SEC = 1;

    typedef enum logic {
        HB_IDLE = 1'b0,
        HB_RUN  = 1'b1
    } hb_run_e;

endpackage

// File: rtl/hb_pwm_timebase.sv
// Up-counting period timer with boundary-loaded working settings.
// Exposes both the registered state and the next-state values so the
// downstream stages can register their outputs aligned with the timer.
module hb_pwm_timebase
    import hb_pwm_pkg::*;
#(
    parameter int CNT_W = HB_CNT_W,
    parameter int DB_W  = HB_DB_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [DB_W-1:0]  dead_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             run_d_o,
    output logic [CNT_W-1:0] tmr_d_o,
    output logic [CNT_W-1:0] duty_d_o,
    output logic [DB_W-1:0]  db_d_o,
    output logic             run_q_o,
    output logic [CNT_W-1:0] tmr_q_o,
    output logic [CNT_W-1:0] pr_q_o,
    output logic [DB_W-1:0]  db_q_o,
    output logic             strobe_q_o
);

    localparam logic [CNT_W-1:0] TMR_ZERO = '0;
    localparam logic [CNT_W-1:0] TMR_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        hb_run_e          run;
        logic [CNT_W-1:0] tmr;
        logic [CNT_W-1:0] pr;
        logic [CNT_W-1:0] duty;
        logic [DB_W-1:0]  db;
        logic             stb;
    } tb_state_t;

    tb_state_t s_q, s_d;

    logic at_boundary;

    always_comb begin
        at_boundary = (s_q.run == HB_IDLE) || (s_q.tmr == s_q.pr);
        s_d         = s_q;
        s_d.stb     = 1'b0;
        if (!en_i) begin
            s_d.run = HB_IDLE;
            s_d.tmr = TMR_ZERO;
        end else if (at_boundary) begin
            s_d.run  = HB_RUN;
            s_d.tmr  = TMR_ZERO;
            s_d.pr   = period_i;
            s_d.duty = duty_i;
            s_d.db   = dead_i;
            s_d.stb  = 1'b1;
        end else begin
            s_d.tmr = s_q.tmr + TMR_ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_d_o    = (s_d.run == HB_RUN) && !rst_i;
    assign tmr_d_o    = s_d.tmr;
    assign duty_d_o   = s_d.duty;
    assign db_d_o     = s_d.db;
    assign run_q_o    = (s_q.run == HB_RUN);
    assign tmr_q_o    = s_q.tmr;
    assign pr_q_o     = s_q.pr;
    assign db_q_o     = s_q.db;
    assign strobe_q_o = s_q.stb;

endmodule

// File: rtl/hb_pwm_compare.sv
// Nominal phase decision: primary phase while the timer is below duty.
module hb_pwm_compare #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] tmr_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             pri_phase_o
);

    always_comb begin
        pri_phase_o = (tmr_i < duty_i);
    end

endmodule

// File: rtl/hb_pwm_deadband.sv
// Tracks cycles since the last nominal phase change and releases an
// output only once that age reaches the dead-band count.
module hb_pwm_deadband
    import hb_pwm_pkg::*;
#(
    parameter int DB_W = HB_DB_W
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            run_d_i,
    input  logic            pri_phase_d_i,
    input  logic [DB_W-1:0] db_d_i,
    output logic            pri_o,
    output logic            sec_o
);

    localparam logic [DB_W-1:0] AGE_MAX  = {DB_W{1'b1}};
    localparam logic [DB_W-1:0] AGE_ZERO = '0;
    localparam logic [DB_W-1:0] AGE_ONE  = {{(DB_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic                  run;
        logic                  phase;
        logic [DB_W-1:0]       age;
        logic [HB_NUM_OUT-1:0] outs;
    } db_state_t;

    db_state_t s_q, s_d;

    logic                  phase_change;
    logic [DB_W-1:0]       age_nxt;
    logic [HB_NUM_OUT-1:0] gate;
    logic [HB_NUM_OUT-1:0] want;

    // Age of the current nominal phase, saturating at its maximum.
    always_comb begin
        phase_change = !s_q.run || (pri_phase_d_i != s_q.phase);
        if (phase_change) begin
            age_nxt = AGE_ZERO;
        end else if (s_q.age == AGE_MAX) begin
            age_nxt = AGE_MAX;
        end else begin
            age_nxt = s_q.age + AGE_ONE;
        end
    end

    assign want[HB_OUT_PRI] = pri_phase_d_i;
    assign want[HB_OUT_SEC] = !pri_phase_d_i;

    for (genvar g = 0; g < HB_NUM_OUT; g++) begin : g_gate
        assign gate[g] = want[g] && (age_nxt >= db_d_i);
    end

    always_comb begin
        s_d = s_q;
        if (!run_d_i) begin
            s_d = '0;
        end else begin
            s_d.run   = 1'b1;
            s_d.phase = pri_phase_d_i;
            s_d.age   = age_nxt;
            s_d.outs  = gate;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pri_o = s_q.outs[HB_OUT_PRI];
    assign sec_o = s_q.outs[HB_OUT_SEC];

endmodule

// File: rtl/hb_pwm.sv
// Half-bridge complementary PWM generator with programmable dead-band.
module hb_pwm
    import hb_pwm_pkg::*;
#(
    parameter int CNT_W = HB_CNT_W,
    parameter int DB_W  = HB_DB_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DB_W-1:0]  dead_i,
    output logic             pwm_a_o,
    output logic             pwm_b_o,
    output logic             strobe_o
);

    logic             run_d_w;
    logic [CNT_W-1:0] tmr_d_w;
    logic [CNT_W-1:0] duty_d_w;
    logic [DB_W-1:0]  db_d_w;
    logic             run_w;
    logic [CNT_W-1:0] tmr_w;
    logic [CNT_W-1:0] pr_w;
    logic [DB_W-1:0]  db_w;
    logic             pri_phase_d_w;

    hb_pwm_timebase #(
        .CNT_W (CNT_W),
        .DB_W  (DB_W)
    ) u_timebase (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .en_i       (en_i),
        .period_i   (period_i),
        .dead_i     (dead_i),
        .duty_i     (duty_i),
        .run_d_o    (run_d_w),
        .tmr_d_o    (tmr_d_w),
        .duty_d_o   (duty_d_w),
        .db_d_o     (db_d_w),
        .run_q_o    (run_w),
        .tmr_q_o    (tmr_w),
        .pr_q_o     (pr_w),
        .db_q_o     (db_w),
        .strobe_q_o (strobe_o)
    );

    hb_pwm_compare #(
        .CNT_W (CNT_W)
    ) u_compare (
        .tmr_i       (tmr_d_w),
        .duty_i      (duty_d_w),
        .pri_phase_o (pri_phase_d_w)
    );

    hb_pwm_deadband #(
        .DB_W (DB_W)
    ) u_deadband (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .run_d_i       (run_d_w),
        .pri_phase_d_i (pri_phase_d_w),
        .db_d_i        (db_d_w),
        .pri_o         (pwm_a_o),
        .sec_o         (pwm_b_o)
    );

endmodule

// File: rtl/hb_pwm_chk.sv
// Property checker attached to the PWM top.
module hb_pwm_chk #(
    parameter int CNT_W = 8,
    parameter int DB_W  = 7
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             en_i,
    input logic             pwm_a,
    input logic             pwm_b,
    input logic             strobe,
    input logic             run,
    input logic [CNT_W-1:0] tmr,
    input logic [CNT_W-1:0] pr,
    input logic [DB_W-1:0]  db
);

    assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !(pwm_a && pwm_b));

    assert_timer_bound_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        run |-> (tmr <= pr));

    assert_strobe_slot0_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe |-> (run && tmr == '0));

    assert_zero_gap_complement_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (run && db == '0) |-> (pwm_a ^ pwm_b));

    assert_gap_before_a_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (db != '0 && $rose(pwm_a)) |-> !$past(pwm_b));

    assert_gap_before_b_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (db != '0 && $rose(pwm_b)) |-> !$past(pwm_a));

    assert_disable_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!pwm_a && !pwm_b && !strobe && !run));

endmodule

bind hb_pwm hb_pwm_chk #(
    .CNT_W (CNT_W),
    .DB_W  (DB_W)
) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (en_i),
    .pwm_a  (pwm_a_o),
    .pwm_b  (pwm_b_o),
    .strobe (strobe_o),
    .run    (run_w),
    .tmr    (tmr_w),
    .pr     (pr_w),
    .db     (db_w)
);

// File: tb/hb_pwm_tb.sv
`timescale 1ns/1ps
module hb_pwm_tb_top;

    localparam int CNT_W = 8;
    localparam int DB_W  = 7;
    localparam int AGE_SAT = (1 << DB_W) - 1;

    logic             clk = 1'b0;
    logic             rst;
    logic             en;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
    logic [DB_W-1:0]  dead;
    logic             pwm_a, pwm_b, stb;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    string cur_req = "R8";
    bit done = 1'b0;

    always #2 clk = ~clk;

    hb_pwm #(.CNT_W(CNT_W), .DB_W(DB_W)) dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .en_i     (en),
        .period_i (period),
        .duty_i   (duty),
        .dead_i   (dead),
        .pwm_a_o  (pwm_a),
        .pwm_b_o  (pwm_b),
        .strobe_o (stb)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: a running timer, latched settings, and the
    // number of cycles the nominal phase has lasted.
    int  m_t = 0, m_pr = 0, m_du = 0, m_db = 0, m_age = 0;
    bit  m_run = 0, m_pri = 0, m_a = 0, m_b = 0, m_s = 0;

    always @(posedge clk) begin
        cycles++;
        if (rst || !en) begin
            m_run = 0; m_t = 0; m_a = 0; m_b = 0; m_s = 0; m_age = 0; m_pri = 0;
            if (rst) begin m_pr = 0; m_du = 0; m_db = 0; end
        end else begin
            bit fresh;
            bit pri_now;
            fresh = !m_run;
            if (!m_run || m_t == m_pr) begin
                m_t = 0; m_pr = period; m_du = duty; m_db = dead; m_s = 1;
            end else begin
                m_t = m_t + 1; m_s = 0;
            end
            pri_now = (m_t < m_du);
            if (fresh || pri_now != m_pri) m_age = 0;
            else if (m_age < AGE_SAT) m_age = m_age + 1;
            m_pri = pri_now;
            m_a = pri_now && (m_age >= m_db);
            m_b = !pri_now && (m_age >= m_db);
            m_run = 1;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk(pwm_a == m_a, cur_req, "pwm_a vs model", pwm_a, m_a);
            chk(pwm_b == m_b, cur_req, "pwm_b vs model", pwm_b, m_b);
            chk(stb == m_s, "R9", "strobe vs model", stb, m_s);
            chk(!(pwm_a && pwm_b), "R5", "overlap", pwm_a && pwm_b, 0);
        end
    end

    always @(posedge clk) begin
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 50000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_strobe();
        do @(negedge clk); while (!stb);
    endtask

    // Program settings, let them load, skip one settling period, then
    // count output-high cycles over one full period.
    task automatic period_counts(input int pr, input int du, input int db,
                                 input int exp_a, input int exp_b, input string req);
        int ca = 0, cb = 0;
        cur_req = req;
        period = pr[CNT_W-1:0]; duty = du[CNT_W-1:0]; dead = db[DB_W-1:0];
        wait_strobe();
        wait_strobe();
        for (int i = 0; i <= pr; i++) begin
            if (i != 0) @(negedge clk);
            ca += int'(pwm_a);
            cb += int'(pwm_b);
        end
        chk(ca == exp_a, req, "primary high cycles", ca, exp_a);
        chk(cb == exp_b, req, "secondary high cycles", cb, exp_b);
    endtask

    initial begin
        int gap;
        rst = 1; en = 0; period = 9; duty = 4; dead = 0;
        repeat (3) @(negedge clk);
        chk(!pwm_a && !pwm_b && !stb, "R8", "reset outputs",
            {pwm_a, pwm_b, stb}, 0);
        rst = 0;
        @(negedge clk);
        en = 1;

        // R1/R9: strobe spacing equals PR+1
        cur_req = "R1";
        wait_strobe();
        gap = 0;
        do begin @(negedge clk); gap++; end while (!stb);
        chk(gap == 10, "R1", "period length PR=9", gap, 10);

        period_counts(9, 4, 0, 4, 6, "R2");
        period_counts(9, 4, 2, 2, 4, "R3");
        period_counts(9, 4, 5, 0, 1, "R4");
        period_counts(9, 4, 7, 0, 0, "R4");
        period_counts(9, 0, 3, 0, 10, "R6");
        period_counts(9, 12, 3, 10, 0, "R6");
        period_counts(3, 2, 1, 1, 1, "R3");

        cur_req = "R1";
        period = 3;
        wait_strobe();
        gap = 0;
        do begin @(negedge clk); gap++; end while (!stb);
        chk(gap == 4, "R1", "period length PR=3", gap, 4);

        // R7: mid-period duty change is deferred to the next boundary
        period_counts(9, 4, 0, 4, 6, "R7");
        wait_strobe();
        @(negedge clk);
        duty = 8;
        repeat (4) @(negedge clk);
        chk(pwm_a == 0 && pwm_b == 1, "R7", "slot 5 uses old duty",
            {pwm_a, pwm_b}, 1);
        period_counts(9, 8, 0, 8, 2, "R7");

        // R8/R9: disable mid-period, then restart at slot 0
        cur_req = "R8";
        repeat (3) @(negedge clk);
        en = 0;
        @(negedge clk);
        chk(!pwm_a && !pwm_b && !stb, "R8", "outputs after disable",
            {pwm_a, pwm_b, stb}, 0);
        repeat (3) @(negedge clk);
        en = 1;
        @(negedge clk);
        chk(stb == 1, "R9", "strobe on first enabled cycle", stb, 1);
        chk(pwm_a == 1, "R8", "primary high in slot 0 with zero dead-band", pwm_a, 1);

        // R8: enable restart counts as a turn-on, so dead-band applies
        en = 0; dead = 3;
        @(negedge clk);
        en = 1;
        @(negedge clk);
        chk(pwm_a == 0, "R8", "primary held in slot 0 after restart", pwm_a, 0);
        repeat (3) @(negedge clk);
        chk(pwm_a == 1, "R3", "primary released after 3 cycles", pwm_a, 1);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule